// File: doc/BRIEF.md
# BCD Calendar Clock with Start Gate

This block keeps wall-clock time and calendar date in packed BCD: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A prescaler divides the reference clock, nominally 32.768 kHz, into a one-second tick. Each tick advances the seconds field, and carries ripple through minutes, hours, day, month and year within the same reference cycle. The day-of-month limit follows the month length. February gets a 29th day in leap years.

Software loads any field through a byte-wide write port. A control register bit selects how hours are coded: 24-hour, or 12-hour with an AM/PM flag. After reset, which stands for a total power loss, the clock holds still. It starts counting only once software has written a time or date byte. Writing the seconds field restarts the prescaler, so the first increment arrives one full second after that write.

Top module: `bcd_calendar_clock`

## Requirements
- R1: While running, the prescaler raises `tick_o` for one reference cycle in every PRESCALE_DIV cycles, and each tick advances the seconds field once.
- R2: Seconds and minutes count 00 to 59 in BCD. Each wraps to 00 and carries into the next field on the tick after 59.
- R3: In 24-hour mode the hour counts 00 to 23 in BCD. The step from 23:59:59 goes to 00:00:00 and advances the day.
- R4: In 12-hour mode, hour bits [4:0] hold BCD 12, 01, …, 11 and bit 7 is the PM flag (1 = PM). The flag toggles when the hour steps from 11 to 12. The day advances only on the step from 11 PM to 12 AM.
- R5: Day of month counts from 01 and wraps to 01 after day 30 for months 04, 06, 09 and 11, and after day 31 for the other months except February.
- R6: February wraps after day 29 when the BCD year is divisible by four (00 counts as a leap year), and after day 28 otherwise.
- R7: The month wraps from 12 to 01 and then increments the year. The year wraps from 99 to 00.
- R8: Day of week counts 0 to 6 and advances at each midnight, wrapping from 6 to 0.
- R9: Reset sets 00:00:00, day of week 0, date 01, month 01, year 00 and 24-hour mode, with `running_o` low. No field advances, and `tick_o` stays low, until a write to one of addresses 0 to 6. A write to address 7 does not start the clock.
- R10: A write to the seconds field clears the prescaler. The next seconds increment occurs exactly PRESCALE_DIV cycles after the write edge.
- R11: Write addresses are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7 control. A written byte appears on the field output after that edge. A write takes precedence over a carry into the same field in the same cycle, and that field then passes no carry onward.
- R12: Bit 0 of a control write selects 12-hour mode (1) or 24-hour mode (0), and `mode_12h_o` reflects the selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset (cold start) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours, BCD, with PM flag in bit 7 in 12-hour mode |
| dow_o | output | 8 | Day of week 0 to 6 |
| date_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year 00 to 99, BCD |
| mode_12h_o | output | 1 | 12-hour mode selected |
| running_o | output | 1 | Start gate open |
| tick_o | output | 1 | One-second tick strobe |

## Verification
The bench builds the block with PRESCALE_DIV set to 16, so one second lasts sixteen reference cycles. Every increment and every carry chain can then be reached within a few hundred cycles. Because fields can be loaded, the bench jumps straight to the end of a month, a year or a leap-year February and steps across the boundary a few seconds later. The short second also lets it land a write exactly on a tick edge, which tests write-over-carry precedence and the prescaler restart to the cycle.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  typedef enum logic [2:0] {
    A_SEC   = 3'd0,
    A_MIN   = 3'd1,
    A_HOUR  = 3'd2,
    A_DOW   = 3'd3,
    A_DATE  = 3'd4,
    A_MONTH = 3'd5,
    A_YEAR  = 3'd6,
    A_CTRL  = 3'd7
  } reg_addr_e;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // two-digit BCD year divisible by four
  function automatic logic is_leap(input logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
  endfunction

  function automatic logic [7:0] month_days(input logic [7:0] mon, input logic [7:0] y);
    case (mon)
      8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRESCALE_DIV = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clear_i,
  output logic tick_o
);
  localparam int CNT_W = (PRESCALE_DIV > 1) ? $clog2(PRESCALE_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PRESCALE_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clear_i || !run_i)   cnt_q <= '0;
    else if (tick_o)              cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);
  p_tick_gap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((PRESCALE_DIV > 1) && tick_o) |=> !tick_o);
  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0));

endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter logic [7:0] RST_VAL = 8'h00
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] load_val_i,
  input  logic       inc_i,
  input  logic [7:0] lo_i,
  input  logic [7:0] hi_i,
  output logic [7:0] val_o,
  output logic       carry_o
);
  import rtc_cal_pkg::*;

  logic [7:0] val_q;
  logic       at_top;

  // >= so a value left past a shortened limit still wraps
  assign at_top  = (val_q >= hi_i);
  assign carry_o = inc_i && !load_i && at_top;
  assign val_o   = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= RST_VAL;
    else if (load_i) val_q <= load_val_i;
    else if (inc_i)  val_q <= at_top ? lo_i : bcd_inc(val_q);
  end

  p_wrap_lo_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i && at_top) |=> (val_q == $past(lo_i)));
  p_load_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (val_q == $past(load_val_i)));

endmodule

// File: rtl/rtc_hour_field.sv
module rtc_hour_field (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode12_i,
  input  logic       load_i,
  input  logic [7:0] load_val_i,
  input  logic       inc_i,
  output logic [7:0] val_o,
  output logic       carry_o
);
  import rtc_cal_pkg::*;

  logic [7:0] val_q, nxt;
  logic       wrap;
  logic [7:0] h12;
  logic [7:0] h12_inc;

  assign h12     = {3'b000, val_q[4:0]};
  assign h12_inc = bcd_inc(h12);

  always_comb begin
    nxt  = val_q;
    wrap = 1'b0;
    if (mode12_i) begin
      if (h12 >= 8'h12)      nxt = {val_q[7], 7'h01};
      else if (h12 == 8'h11) begin
        nxt  = {~val_q[7], 7'h12};
        wrap = val_q[7];        // 11 PM -> 12 AM
      end else               nxt = {val_q[7], 2'b00, h12_inc[4:0]};
    end else begin
      if (val_q >= 8'h23) begin
        nxt  = 8'h00;
        wrap = 1'b1;
      end else               nxt = bcd_inc(val_q);
    end
  end

  assign carry_o = inc_i && !load_i && wrap;
  assign val_o   = val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     val_q <= 8'h00;
    else if (load_i) val_q <= load_val_i;
    else if (inc_i)  val_q <= nxt;
  end

  p_pm_toggle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode12_i && inc_i && !load_i && val_q[4:0] == 5'h11)
    |=> (val_q[7] != $past(val_q[7])) && (val_q[4:0] == 5'h12));
  p_midnight_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode12_i && inc_i && !load_i && val_q == 8'h23) |=> (val_q == 8'h00));

endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock #(
  parameter int PRESCALE_DIV = 32768
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [2:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic       mode_12h_o,
  output logic       running_o,
  output logic       tick_o
);
  import rtc_cal_pkg::*;

  localparam int NREG = 8;

  logic [NREG-1:0] wr_sel;
  logic            run_q, mode_q;
  logic            pre_tick, tick_eff;
  logic            c_sec, c_min, c_hour, c_dow, c_date, c_month, c_year;
  logic [7:0]      dim;

  assign wr_sel = wr_en_i ? (NREG'(1) << wr_addr_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      if (|wr_sel[A_YEAR:A_SEC]) run_q  <= 1'b1;
      if (wr_sel[A_CTRL])        mode_q <= wr_data_i[0];
    end
  end

  rtc_prescaler #(.PRESCALE_DIV(PRESCALE_DIV)) u_pre (
    .clk_i, .rst_ni, .run_i(run_q), .clear_i(wr_sel[A_SEC]), .tick_o(pre_tick)
  );

  assign tick_eff = pre_tick && !wr_sel[A_SEC];
  assign dim      = month_days(month_o, year_o);

  rtc_bcd_field #(.RST_VAL(8'h00)) u_sec (
    .clk_i, .rst_ni, .load_i(wr_sel[A_SEC]), .load_val_i(wr_data_i), .inc_i(tick_eff),
    .lo_i(8'h00), .hi_i(8'h59), .val_o(sec_o), .carry_o(c_sec));

  rtc_bcd_field #(.RST_VAL(8'h00)) u_min (
    .clk_i, .rst_ni, .load_i(wr_sel[A_MIN]), .load_val_i(wr_data_i), .inc_i(c_sec),
    .lo_i(8'h00), .hi_i(8'h59), .val_o(min_o), .carry_o(c_min));

  rtc_hour_field u_hour (
    .clk_i, .rst_ni, .mode12_i(mode_q), .load_i(wr_sel[A_HOUR]), .load_val_i(wr_data_i),
    .inc_i(c_min), .val_o(hour_o), .carry_o(c_hour));

  rtc_bcd_field #(.RST_VAL(8'h00)) u_dow (
    .clk_i, .rst_ni, .load_i(wr_sel[A_DOW]), .load_val_i(wr_data_i), .inc_i(c_hour),
    .lo_i(8'h00), .hi_i(8'h06), .val_o(dow_o), .carry_o(c_dow));

  rtc_bcd_field #(.RST_VAL(8'h01)) u_date (
    .clk_i, .rst_ni, .load_i(wr_sel[A_DATE]), .load_val_i(wr_data_i), .inc_i(c_hour),
    .lo_i(8'h01), .hi_i(dim), .val_o(date_o), .carry_o(c_date));

  rtc_bcd_field #(.RST_VAL(8'h01)) u_month (
    .clk_i, .rst_ni, .load_i(wr_sel[A_MONTH]), .load_val_i(wr_data_i), .inc_i(c_date),
    .lo_i(8'h01), .hi_i(8'h12), .val_o(month_o), .carry_o(c_month));

  rtc_bcd_field #(.RST_VAL(8'h00)) u_year (
    .clk_i, .rst_ni, .load_i(wr_sel[A_YEAR]), .load_val_i(wr_data_i), .inc_i(c_month),
    .lo_i(8'h00), .hi_i(8'h99), .val_o(year_o), .carry_o(c_year));

  assign mode_12h_o = mode_q;
  assign running_o  = run_q;
  assign tick_o     = tick_eff;

  p_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_o |-> !tick_o);
  p_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i != A_CTRL) |=> running_o);
  p_sec_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && sec_o == 8'h59) |=> (sec_o == 8'h00));
  p_leap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_hour && !wr_en_i && month_o == 8'h02 && date_o == 8'h28 && is_leap(year_o))
    |=> (date_o == 8'h29));
  p_dow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_hour && !wr_en_i && dow_o == 8'h06) |=> (dow_o == 8'h00));
  p_year_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_month && !wr_en_i && year_o == 8'h99) |=> (year_o == 8'h00));

  // year carry has no consumer
  logic unused_ok;
  assign unused_ok = c_dow ^ c_year;

endmodule

// File: tb/bcd_calendar_clock_tb.sv
`timescale 1ns/1ps
module bcd_calendar_clock_tb;

  localparam int DIV = 16;

  typedef struct {
    int s, m, h, dw, d, mo, y;
  } tm_t;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;
  logic       mode_12h_o, running_o, tick_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  bcd_calendar_clock #(.PRESCALE_DIV(DIV)) u_dut (.*);

  function automatic logic [7:0] to_bcd(int v);
    return 8'(((v / 10) << 4) + (v % 10));
  endfunction

  function automatic logic [7:0] hr_enc(int h, bit m12);
    int h12;
    if (!m12) return to_bcd(h);
    h12 = (h % 12 == 0) ? 12 : h % 12;
    return ((h >= 12) ? 8'h80 : 8'h00) | to_bcd(h12);
  endfunction

  function automatic int dim(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic tm_t adv(tm_t t);
    tm_t n = t;
    n.s++;
    if (n.s < 60) return n;
    n.s = 0; n.m++;
    if (n.m < 60) return n;
    n.m = 0; n.h++;
    if (n.h < 24) return n;
    n.h = 0;
    n.dw = (n.dw + 1) % 7;
    n.d++;
    if (n.d <= dim(n.mo, n.y)) return n;
    n.d = 1; n.mo++;
    if (n.mo <= 12) return n;
    n.mo = 1;
    n.y = (n.y + 1) % 100;
    return n;
  endfunction

  function automatic tm_t mk(int y, int mo, int d, int dw, int h, int m, int s);
    tm_t t;
    t.y = y; t.mo = mo; t.d = d; t.dw = dw; t.h = h; t.m = m; t.s = s;
    return t;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_tm(string tag, tm_t t, bit m12);
    chk(tag, {8'h00, sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o},
        {8'h00, to_bcd(t.s), to_bcd(t.m), hr_enc(t.h, m12), to_bcd(t.dw),
         to_bcd(t.d), to_bcd(t.mo), to_bcd(t.y)});
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // seconds first (edge E0), control last (edge E7)
  task automatic load(tm_t t, bit m12);
    wr(3'd0, to_bcd(t.s));
    wr(3'd1, to_bcd(t.m));
    wr(3'd2, hr_enc(t.h, m12));
    wr(3'd3, to_bcd(t.dw));
    wr(3'd4, to_bcd(t.d));
    wr(3'd5, to_bcd(t.mo));
    wr(3'd6, to_bcd(t.y));
    wr(3'd7, {7'd0, m12});
  endtask

  // after load: sample just after edge E(DIV*k)
  task automatic after_ticks(int k);
    repeat (DIV * k - 7) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic step_case(string tag, tm_t t, bit m12, int k);
    tm_t e = t;
    load(t, m12);
    after_ticks(k);
    for (int i = 0; i < k; i++) e = adv(e);
    chk_tm(tag, e, m12);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tm_t t, e;
    int  tk;
    void'($urandom(32'h5eed_c10c));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R9 reset state
    chk("R9 reset", {sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o, 6'd0, mode_12h_o, running_o},
        {8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00});
    tk = 0;
    for (int i = 0; i < 5 * DIV; i++) begin
      @(negedge clk_i);
      tk += int'(tick_o);
    end
    chk("R9 hold before write", {tk, 24'd0, sec_o, running_o}, {32'd0, 24'd0, 8'h00, 1'b0});

    // R12 / R9: control write sets mode but does not start
    wr(3'd7, 8'h01);
    repeat (3 * DIV) @(negedge clk_i);
    chk("R12 mode set", {63'd0, mode_12h_o}, 64'd1);
    chk("R9 ctrl write no start", {running_o, sec_o}, {1'b0, 8'h00});
    wr(3'd7, 8'h00);
    chk("R12 mode clear", {63'd0, mode_12h_o}, 64'd0);

    // R9 start on year write
    wr(3'd6, 8'h42);
    chk("R9 start", {running_o, year_o}, {1'b1, 8'h42});

    // R10 seconds write restarts prescaler
    load(mk(10, 3, 5, 2, 8, 20, 10), 1'b0);
    repeat (8) @(posedge clk_i);
    @(negedge clk_i);
    chk("R10 no tick at DIV-1", {56'd0, sec_o}, 64'h10);
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R10 tick at DIV", {56'd0, sec_o}, 64'h11);

    // R1 tick rate
    tk = 0;
    for (int i = 0; i < 10 * DIV; i++) begin
      @(negedge clk_i);
      tk += int'(tick_o);
    end
    chk("R1 tick count", 64'(tk), 64'd10);
    chk("R1 seconds advanced", {56'd0, sec_o}, 64'h21);

    // R11 write precedence over carry
    load(mk(5, 6, 7, 1, 14, 10, 59), 1'b0);
    repeat (8) @(posedge clk_i);
    @(negedge clk_i);
    wr(3'd1, 8'h33);
    chk_tm("R11 write beats carry", mk(5, 6, 7, 1, 14, 33, 0), 1'b0);

    // directed boundaries
    step_case("R6 leap feb 28", mk(24, 2, 28, 3, 23, 59, 59), 1'b0, 1);
    chk("R6 leap date", {56'd0, date_o}, 64'h29);
    step_case("R6 non-leap feb 28", mk(23, 2, 28, 3, 23, 59, 59), 1'b0, 1);
    chk("R6 non-leap month", {month_o, date_o}, {8'h03, 8'h01});
    step_case("R6 year 00 feb 29", mk(0, 2, 29, 4, 23, 59, 58), 1'b0, 3);
    step_case("R5 apr 30", mk(31, 4, 30, 5, 23, 59, 59), 1'b0, 1);
    chk("R5 may 1", {month_o, date_o}, {8'h05, 8'h01});
    step_case("R5 jan 31", mk(31, 1, 31, 5, 23, 59, 59), 1'b0, 2);
    step_case("R7 year wrap", mk(99, 12, 31, 2, 23, 59, 59), 1'b0, 1);
    chk("R7 year 00", {month_o, year_o}, {8'h01, 8'h00});
    step_case("R8 dow wrap", mk(50, 7, 9, 6, 23, 59, 59), 1'b0, 1);
    chk("R8 dow 0", {56'd0, dow_o}, 64'h00);
    step_case("R3 24h noon", mk(12, 8, 8, 0, 11, 59, 59), 1'b0, 1);
    step_case("R4 11 AM to 12 PM", mk(12, 8, 8, 0, 11, 59, 59), 1'b1, 1);
    chk("R4 pm flag", {56'd0, hour_o}, 64'h92);
    step_case("R4 11 PM to 12 AM", mk(12, 8, 8, 0, 23, 59, 59), 1'b1, 1);
    chk("R4 midnight", {hour_o, date_o}, {8'h12, 8'h09});
    step_case("R4 12 to 01", mk(12, 8, 8, 0, 12, 59, 59), 1'b1, 1);
    chk("R4 one pm", {56'd0, hour_o}, 64'h81);

    // constrained random near rollovers
    for (int n = 0; n < 40; n++) begin
      bit m12 = 1'($urandom_range(0, 1));
      int y   = ($urandom_range(0, 1) == 1) ? 4 * $urandom_range(0, 24) : $urandom_range(0, 99);
      int mo  = $urandom_range(1, 12);
      int d   = dim(mo, y) - $urandom_range(0, 1);
      int h   = ($urandom_range(0, 2) == 0) ? $urandom_range(0, 23) :
                (($urandom_range(0, 1) == 1) ? 23 : 11);
      int m   = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 58) : 59;
      int s   = $urandom_range(45, 59);
      int k   = $urandom_range(1, 20);
      if (mo == 12 && $urandom_range(0, 3) == 0) y = 99;
      t = mk(y, mo, d, $urandom_range(0, 6), h, m, s);
      step_case("R2 R3 R4 R5 R7 R8 random", t, m12, k);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule